// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register bank for a multi-channel, descriptor-driven DMA engine. A processor reaches it over a simple 32-bit word bus. The 4 KB address window is divided into equal channel slots, and each slot holds sixteen word registers. Descriptor execution is not done here. A separate sequencer takes each channel's status word, its command pointer and its three condition-select words from dedicated output buses.

Software controls a channel through a control register, which is write-only. Each write carries its own per-bit write mask, so individual control bits can be set or cleared without a read-modify-write. After the merge, the busy (ACTIVE) and failed (DEAD) flags are worked out by fixed precedence rules. Software never writes them directly.

The command pointer is protected. A write to it while the channel is running or busy has no effect. An accepted write aligns the pointer to 16 bytes and sends a fetch pulse to the sequencer. When a control write leaves a channel busy, the block sends a run-request pulse. The sequencer reports a fatal error through a kill input and a halt through a stop input.

Top module: `dma_chan_regfile`

## Requirements
- R1: Address bits [11:7] select one of 32 channels, and bits [6:2] select a register index inside the slot. The index assignments are:
  - control = 0, status = 1, pointer-high = 2, pointer-low = 3
  - interrupt-select = 4, branch-select = 5, wait-select = 6, transfer-mode = 7
  - data2-high = 8, data2-low = 9, spare-A = 10, address-high = 11, branch-address-high = 12
  - spare-B/C/D = 13/14/15
  - Indices 16 to 31 have no storage.
- R2: The status word bit positions are RUN = bit 15, PAUSE = 14, FLUSH = 13, WAKE = 12, DEAD = 11, ACTIVE = 10 and BT = 8. Bits [7:0] hold the device status. Bit 9 is always 0.
- R3: A control write uses bits [31:16] as a mask and bits [15:0] as values. The effective mask is the written mask ANDed with 0xF0FF. Only RUN, PAUSE, FLUSH, WAKE and device status can change. The merged status is (value & effective mask) | (old & ~effective mask).
- R4: After the merge, four rules apply in this order:
  1. WAKE set forces ACTIVE.
  2. RUN set forces ACTIVE and clears DEAD.
  3. PAUSE set clears ACTIVE.
  4. If RUN was 1 before the write and is 0 after it, both ACTIVE and DEAD are cleared.
- R5: A pointer-low write is ignored while the channel's RUN or ACTIVE bit is set.
- R6: An accepted pointer-low write stores the written word with bits [3:0] forced to zero. In the cycle after the write, the fetch output for that channel is high for exactly one cycle.
- R7: These reads return zero:
  - the control register
  - pointer-high, transfer-mode, data2-high, data2-low, address-high and branch-address-high
  - any index from 16 to 31
  
  A status read returns the 16-bit status zero-extended. Bus writes to the status register and to the zero-reading registers leave all state unchanged.
- R8: The three select registers and the four spare registers read back the full 32-bit word last written.
- R9: When a control write leaves ACTIVE set, that channel's run-request output is high for exactly one cycle, in the cycle after the write.
- R10: A kill input sets DEAD and clears ACTIVE. A stop input clears ACTIVE and DEAD. Either input acts on the status after any control write in the same cycle, and kill takes precedence over stop.
- R11: A synchronous active-low reset clears every register of every channel, both pulse outputs and the read data.
- R12: Read data appears in the cycle after the read strobe. It reflects state from before any write in that same cycle, and it holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address in the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| seq_kill_i | input | 32 | Per-channel fatal-error hook from the sequencer |
| seq_stop_i | input | 32 | Per-channel halt hook from the sequencer |
| chan_status_o | output | 512 | 16-bit status per channel, channel 0 in the low bits |
| chan_cmdptr_o | output | 1024 | Command pointer per channel |
| chan_isel_o | output | 1024 | Interrupt condition select per channel |
| chan_bsel_o | output | 1024 | Branch condition select per channel |
| chan_wsel_o | output | 1024 | Wait condition select per channel |
| run_req_o | output | 32 | One-cycle run request per channel |
| fetch_o | output | 32 | One-cycle descriptor-fetch start per channel |

## Verification
The hardest states to reach are a channel that is busy without RUN, and a control write and a sequencer hook that land on the same channel in the same cycle. Random control words with random masks rarely produce the first case.

The busy-without-RUN state comes from a WAKE-only control write, and a pointer write is then attempted while RUN is clear. The stimulus therefore confines most random traffic to four channels and biases the masks so that WAKE and PAUSE get set. It also injects kill and stop together with control writes, so the bench model must apply the hook after the merge. Directed cases then cover the RUN falling edge, a read and a write in the same cycle, and index values of 16 and above.

// File: rtl/dmareg_pkg.sv
// Shared constants and types for the DMA channel register file.
// Assumes a 16-bit status word; the bit positions are fixed because
// the sequencer decodes them.
package dmareg_pkg;

    localparam int unsigned ST_RUN   = 15;
    localparam int unsigned ST_PAUSE = 14;
    localparam int unsigned ST_FLUSH = 13;
    localparam int unsigned ST_WAKE  = 12;
    localparam int unsigned ST_DEAD  = 11;
    localparam int unsigned ST_ACT   = 10;
    localparam int unsigned ST_BT    = 8;

    // Status bits that a control write is allowed to change.
    localparam logic [15:0] CTL_WRITABLE = 16'hF0FF;

    // Number of registers that exist inside one slot.
    localparam int unsigned SLOT_REGS = 16;

    typedef enum logic [3:0] {
        RI_CTRL  = 4'd0,
        RI_STAT  = 4'd1,
        RI_PTRH  = 4'd2,
        RI_PTRL  = 4'd3,
        RI_ISEL  = 4'd4,
        RI_BSEL  = 4'd5,
        RI_WSEL  = 4'd6,
        RI_XMODE = 4'd7,
        RI_D2H   = 4'd8,
        RI_D2L   = 4'd9,
        RI_SPA   = 4'd10,
        RI_AHI   = 4'd11,
        RI_BHI   = 4'd12,
        RI_SPB   = 4'd13,
        RI_SPC   = 4'd14,
        RI_SPD   = 4'd15
    } reg_idx_e;

    // Masked merge of a control write followed by the flag precedence rules.
    function automatic logic [15:0] ctl_merge(input logic [15:0] old_st,
                                              input logic [31:0] wd);
        logic [15:0] m;
        logic [15:0] s;
        m = wd[31:16] & CTL_WRITABLE;
        s = (wd[15:0] & m) | (old_st & ~m);
        if (s[ST_WAKE]) s[ST_ACT] = 1'b1;
        if (s[ST_RUN]) begin
            s[ST_ACT]  = 1'b1;
            s[ST_DEAD] = 1'b0;
        end
        if (s[ST_PAUSE]) s[ST_ACT] = 1'b0;
        if (old_st[ST_RUN] && !s[ST_RUN]) begin
            s[ST_ACT]  = 1'b0;
            s[ST_DEAD] = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
// Address decoder: splits a byte address into channel number and register
// index, and produces one write select per channel.
// Assumes word access; the two lowest address bits are ignored.
module dmareg_decode #(
    parameter int ADDR_W     = 12,
    parameter int SLOT_SHIFT = 7,
    localparam int NCH       = 1 << (ADDR_W - SLOT_SHIFT),
    localparam int CH_W      = ADDR_W - SLOT_SHIFT,
    localparam int IDX_W     = SLOT_SHIFT - 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic [CH_W-1:0]   chan_o,
    output logic [3:0]        ridx_o,
    output logic              rvalid_o,
    output logic [NCH-1:0]    wsel_o
);
    import dmareg_pkg::*;

    logic [IDX_W-1:0] idx_full;
    logic             unused_lsb;

    // Field extraction from the byte address.
    assign chan_o     = addr_i[ADDR_W-1:SLOT_SHIFT];
    assign idx_full   = addr_i[SLOT_SHIFT-1:2];
    assign ridx_o     = idx_full[3:0];
    assign rvalid_o   = (32'(idx_full) < SLOT_REGS);
    assign unused_lsb = ^addr_i[1:0];

    // One write select per channel slot.
    for (genvar g = 0; g < NCH; g++) begin : g_wsel
        assign wsel_o[g] = wr_i && rvalid_o && (chan_o == CH_W'(g));
    end

endmodule

// File: rtl/dmareg_channel.sv
// One channel's register bank: status with masked control merge, a guarded
// command pointer, three condition selects and four spare words.
// Assumes at most one bus write per cycle; the sequencer hooks act after
// any same-cycle control write.
module dmareg_channel (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wsel_i,
    input  logic [3:0]  ridx_i,
    input  logic [31:0] wdata_i,
    input  logic        kill_i,
    input  logic        stop_i,
    output logic [15:0] status_o,
    output logic [31:0] cmdptr_o,
    output logic [31:0] isel_o,
    output logic [31:0] bsel_o,
    output logic [31:0] wsel_o,
    output logic [127:0] spare_o,
    output logic        run_req_o,
    output logic        fetch_o
);
    import dmareg_pkg::*;

    logic [15:0]      status_q, st_next;
    logic [31:0]      cmdptr_q, isel_q, bsel_q, wsel_q;
    logic [3:0][31:0] spare_q;
    logic             run_req_q, fetch_q;
    logic             ctl_hit, ptr_hit, busy, ptr_ok;
    logic             past_ok_q;

    assign ctl_hit = wsel_i && (ridx_i == RI_CTRL);
    assign ptr_hit = wsel_i && (ridx_i == RI_PTRL);
    assign busy    = status_q[ST_RUN] || status_q[ST_ACT];
    assign ptr_ok  = ptr_hit && !busy;

    // Next status: control merge first, then sequencer hooks.
    always_comb begin
        st_next = status_q;
        if (ctl_hit) st_next = ctl_merge(status_q, wdata_i);
        if (kill_i) begin
            st_next[ST_DEAD] = 1'b1;
            st_next[ST_ACT]  = 1'b0;
        end else if (stop_i) begin
            st_next[ST_DEAD] = 1'b0;
            st_next[ST_ACT]  = 1'b0;
        end
    end

    // Status register and the two one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            run_req_q <= 1'b0;
            fetch_q   <= 1'b0;
        end else begin
            status_q  <= st_next;
            run_req_q <= ctl_hit && st_next[ST_ACT];
            fetch_q   <= ptr_ok;
        end
    end

    // Command pointer, written only while idle and kept 16-byte aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmdptr_q <= '0;
        else if (ptr_ok) cmdptr_q <= {wdata_i[31:4], 4'b0000};
    end

    // Condition select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isel_q <= '0;
            bsel_q <= '0;
            wsel_q <= '0;
        end else if (wsel_i) begin
            if (ridx_i == RI_ISEL) isel_q <= wdata_i;
            if (ridx_i == RI_BSEL) bsel_q <= wdata_i;
            if (ridx_i == RI_WSEL) wsel_q <= wdata_i;
        end
    end

    // Spare storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spare_q <= '0;
        end else if (wsel_i) begin
            case (ridx_i)
                RI_SPA:  spare_q[0] <= wdata_i;
                RI_SPB:  spare_q[1] <= wdata_i;
                RI_SPC:  spare_q[2] <= wdata_i;
                RI_SPD:  spare_q[3] <= wdata_i;
                default: ;
            endcase
        end
    end

    // Marks that one cycle has passed since reset, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assign status_o  = status_q;
    assign cmdptr_o  = cmdptr_q;
    assign isel_o    = isel_q;
    assign bsel_o    = bsel_q;
    assign wsel_o    = wsel_q;
    assign spare_o   = spare_q;
    assign run_req_o = run_req_q;
    assign fetch_o   = fetch_q;

    p_ptr_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_hit && busy) |=> $stable(cmdptr_q));

    p_fetch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && fetch_q) |-> ($past(ptr_hit) && !$past(busy)));

    p_run_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $fell(status_q[ST_RUN]) && !$past(kill_i))
            |-> (!status_q[ST_ACT] && !status_q[ST_DEAD]));

    p_run_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(ctl_hit) && status_q[ST_RUN] && !status_q[ST_PAUSE]
            && !$past(kill_i) && !$past(stop_i)) |-> status_q[ST_ACT]);

    p_pulse_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_req_q |-> status_q[ST_ACT]);

    p_kill_dead_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (status_q[ST_DEAD] && !status_q[ST_ACT]));

    p_bit9_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[9]);

endmodule

// File: rtl/dmareg_readmux.sv
// Registered read path: picks one channel's word by register index.
// Assumes the unused and control indices read as zero.
module dmareg_readmux #(
    parameter int NCH  = 32,
    parameter int CH_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [3:0]        ridx_i,
    input  logic              rvalid_i,
    input  logic [NCH*16-1:0] status_i,
    input  logic [NCH*32-1:0] cmdptr_i,
    input  logic [NCH*32-1:0] isel_i,
    input  logic [NCH*32-1:0] bsel_i,
    input  logic [NCH*32-1:0] wsel_i,
    input  logic [NCH*128-1:0] spare_i,
    output logic [31:0]       rdata_o
);
    import dmareg_pkg::*;

    logic [31:0] word;
    logic [31:0] rdata_q;
    int          c;

    // Word selection for the addressed register.
    always_comb begin
        c    = int'(chan_i);
        word = '0;
        if (rvalid_i) begin
            case (ridx_i)
                RI_STAT: word = {16'h0000, status_i[c*16 +: 16]};
                RI_PTRL: word = cmdptr_i[c*32 +: 32];
                RI_ISEL: word = isel_i[c*32 +: 32];
                RI_BSEL: word = bsel_i[c*32 +: 32];
                RI_WSEL: word = wsel_i[c*32 +: 32];
                RI_SPA:  word = spare_i[c*128 +: 32];
                RI_SPB:  word = spare_i[c*128 + 32 +: 32];
                RI_SPC:  word = spare_i[c*128 + 64 +: 32];
                RI_SPD:  word = spare_i[c*128 + 96 +: 32];
                default: word = '0;
            endcase
        end
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= word;
    end

    assign rdata_o = rdata_q;

    p_ctl_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rvalid_i && ridx_i == RI_CTRL) |=> (rdata_o == 32'h0));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/dma_chan_regfile.sv
// Top of the DMA channel register file: decoder, one bank per channel,
// registered read path, and flat per-channel buses to the sequencer.
// Assumes a single bus master issuing at most one write per cycle.
module dma_chan_regfile #(
    parameter int ADDR_W     = 12,
    parameter int SLOT_SHIFT = 7,
    localparam int NCH       = 1 << (ADDR_W - SLOT_SHIFT),
    localparam int CH_W      = ADDR_W - SLOT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NCH-1:0]     seq_kill_i,
    input  logic [NCH-1:0]     seq_stop_i,
    output logic [NCH*16-1:0]  chan_status_o,
    output logic [NCH*32-1:0]  chan_cmdptr_o,
    output logic [NCH*32-1:0]  chan_isel_o,
    output logic [NCH*32-1:0]  chan_bsel_o,
    output logic [NCH*32-1:0]  chan_wsel_o,
    output logic [NCH-1:0]     run_req_o,
    output logic [NCH-1:0]     fetch_o
);
    logic [CH_W-1:0]    chan;
    logic [3:0]         ridx;
    logic               rvalid;
    logic [NCH-1:0]     wsel_vec;
    logic [NCH*128-1:0] spare_all;

    dmareg_decode #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)) u_dec (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .chan_o   (chan),
        .ridx_o   (ridx),
        .rvalid_o (rvalid),
        .wsel_o   (wsel_vec)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmareg_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wsel_i    (wsel_vec[g]),
            .ridx_i    (ridx),
            .wdata_i   (bus_wdata_i),
            .kill_i    (seq_kill_i[g]),
            .stop_i    (seq_stop_i[g]),
            .status_o  (chan_status_o[g*16 +: 16]),
            .cmdptr_o  (chan_cmdptr_o[g*32 +: 32]),
            .isel_o    (chan_isel_o[g*32 +: 32]),
            .bsel_o    (chan_bsel_o[g*32 +: 32]),
            .wsel_o    (chan_wsel_o[g*32 +: 32]),
            .spare_o   (spare_all[g*128 +: 128]),
            .run_req_o (run_req_o[g]),
            .fetch_o   (fetch_o[g])
        );
    end

    dmareg_readmux #(.NCH(NCH), .CH_W(CH_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (bus_rd_i),
        .chan_i   (chan),
        .ridx_i   (ridx),
        .rvalid_i (rvalid),
        .status_i (chan_status_o),
        .cmdptr_i (chan_cmdptr_o),
        .isel_i   (chan_isel_o),
        .bsel_i   (chan_bsel_o),
        .wsel_i   (chan_wsel_o),
        .spare_i  (spare_all),
        .rdata_o  (bus_rdata_o)
    );

    p_one_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fetch_o) <= 1);

    p_one_runreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_req_o));

endmodule

// File: tb/dma_chan_regfile_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regfile_tb_top;
    localparam int NCH = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NCH-1:0]     kill = '0, stop = '0;
    logic [NCH*16-1:0]  st_o;
    logic [NCH*32-1:0]  ptr_o, isel_o, bsel_o, wsel_o;
    logic [NCH-1:0]     run_req, fetch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_st  [NCH];
    logic [31:0] m_ptr [NCH];
    logic [31:0] m_reg [NCH][16];   // select and spare words by index

    always #10 clk = ~clk;

    dma_chan_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .seq_kill_i(kill), .seq_stop_i(stop), .chan_status_o(st_o),
        .chan_cmdptr_o(ptr_o), .chan_isel_o(isel_o), .chan_bsel_o(bsel_o),
        .chan_wsel_o(wsel_o), .run_req_o(run_req), .fetch_o(fetch)
    );

    task automatic check(input string req, input logic [1023:0] act,
                         input logic [1023:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected status after a control write (R3, R4).
    function automatic logic [15:0] exp_ctl(input logic [15:0] o, input logic [31:0] d);
        logic [15:0] eff;
        logic [15:0] r;
        eff = d[31:16] & 16'hF0FF;
        r = (o & ~eff) | (d[15:0] & eff);
        if (r[12]) r[10] = 1;
        if (r[15]) begin r[10] = 1; r[11] = 0; end
        if (r[14]) r[10] = 0;
        if (o[15] && !r[15]) begin r[10] = 0; r[11] = 0; end
        return r;
    endfunction

    // Expected read word (R7, R8).
    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int ch = int'(a[11:7]);
        int ri = int'(a[6:2]);
        if (ri == 1) return {16'h0, m_st[ch]};
        if (ri == 3) return m_ptr[ch];
        if (ri == 4 || ri == 5 || ri == 6 || ri == 10 || ri >= 13 && ri <= 15)
            return m_reg[ch][ri];
        return 32'h0;
    endfunction

    function automatic logic [NCH*16-1:0] exp_stvec();
        logic [NCH*16-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*16 +: 16] = m_st[i];
        return v;
    endfunction

    function automatic logic [NCH*32-1:0] exp_ptrvec();
        logic [NCH*32-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*32 +: 32] = m_ptr[i];
        return v;
    endfunction

    function automatic logic [NCH*32-1:0] exp_selvec(input int ri);
        logic [NCH*32-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*32 +: 32] = m_reg[i][ri];
        return v;
    endfunction

    // One bus cycle with optional write, read and hooks; checks after the edge.
    task automatic op(input logic we, input logic re, input logic [11:0] a,
                      input logic [31:0] d, input logic [NCH-1:0] k,
                      input logic [NCH-1:0] s, input string req);
        int ch = int'(a[11:7]);
        int ri = int'(a[6:2]);
        logic [31:0] e_rd;
        logic [NCH-1:0] e_run = '0, e_fetch = '0;
        logic ctl = 0;
        logic [15:0] ns;
        @(negedge clk);
        bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = d; kill = k; stop = s;
        e_rd = exp_read(a);
        if (we) begin
            if (ri == 0) ctl = 1;
            if (ri == 3 && !(m_st[ch][15] || m_st[ch][10])) begin
                m_ptr[ch] = {d[31:4], 4'h0};
                e_fetch[ch] = 1;
            end
            if (ri == 4 || ri == 5 || ri == 6 || ri == 10 || ri >= 13 && ri <= 15)
                m_reg[ch][ri] = d;
        end
        for (int i = 0; i < NCH; i++) begin
            ns = m_st[i];
            if (ctl && i == ch) ns = exp_ctl(ns, d);
            if (k[i]) begin ns[11] = 1; ns[10] = 0; end
            else if (s[i]) begin ns[11] = 0; ns[10] = 0; end
            if (ctl && i == ch && ns[10]) e_run[i] = 1;
            m_st[i] = ns;
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; kill = '0; stop = '0;
        check({req, "/R4/R10"}, st_o, exp_stvec(), "status");
        check({req, "/R5"}, ptr_o, exp_ptrvec(), "cmdptr");
        check({req, "/R9"}, run_req, e_run, "run_req");
        check({req, "/R6"}, fetch, e_fetch, "fetch");
        if (re) check({req, "/R12"}, bus_rdata, e_rd, "rdata");
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
        op(1, 0, a, d, '0, '0, req);
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        op(0, 1, a, 32'h0, '0, '0, req);
    endtask

    function automatic logic [11:0] adr(input int ch, input int ri);
        return {5'(ch), 5'(ri), 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd7));
        for (int i = 0; i < NCH; i++) begin
            m_st[i] = '0; m_ptr[i] = '0;
            for (int j = 0; j < 16; j++) m_reg[i][j] = '0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", st_o, '0, "status after reset");
        check("R11", {isel_o, bsel_o, wsel_o}, '0, "selects after reset");
        check("R11", {run_req, fetch, bus_rdata}, '0, "pulses/rdata after reset");
        rst_n = 1;

        // R1/R8: selects and spares land in the addressed slot
        wr(adr(5, 4), 32'hA5A5_0001, "R1");
        wr(adr(5, 5), 32'h1234_5678, "R8");
        wr(adr(5, 6), 32'hDEAD_BEEF, "R8");
        wr(adr(31, 13), 32'hCAFE_0013, "R8");
        check("R1", isel_o, exp_selvec(4), "isel bus");
        check("R1", bsel_o, exp_selvec(5), "bsel bus");
        check("R1", wsel_o, exp_selvec(6), "wsel bus");
        rd(adr(31, 13), "R8");
        rd(adr(5, 4), "R1");
        // R7: zero reads, and writes to status/unused registers are ignored
        wr(adr(5, 0), 32'hFFFF_FFFF, "R3");
        rd(adr(5, 0), "R7");
        wr(adr(5, 1), 32'h0000_0000, "R7");
        rd(adr(5, 1), "R7");
        wr(adr(5, 7), 32'hFFFF_FFFF, "R7");
        rd(adr(5, 7), "R7");
        wr(adr(5, 2), 32'hFFFF_FFFF, "R7");
        rd(adr(5, 2), "R7");
        wr(adr(5, 20), 32'hFFFF_FFFF, "R7");
        rd(adr(5, 20), "R7");
        // R3: mask bits on DEAD/ACTIVE/BT have no effect
        wr(adr(6, 0), 32'h0F00_0F00, "R3");
        // R5: pointer locked while running (ch 5 has RUN set)
        wr(adr(5, 3), 32'h0000_1230, "R5");
        // R4: RUN fall clears ACTIVE and DEAD
        wr(adr(5, 0), 32'h8000_0000, "R4");
        // R6: accepted write aligns and pulses fetch
        wr(adr(5, 3), 32'h1234_567F, "R6");
        rd(adr(5, 3), "R6");
        // R5: busy via WAKE without RUN
        wr(adr(7, 0), 32'h1000_1000, "R4");
        wr(adr(7, 3), 32'h0000_0100, "R5");
        // R4: PAUSE overrides WAKE
        wr(adr(7, 0), 32'h4000_4000, "R4");
        // R10: kill with same-cycle control write; kill beats stop
        op(1, 0, adr(8, 0), 32'h8000_8000, 32'h100, 32'h100, "R10");
        op(1, 0, adr(8, 0), 32'h8000_8000, '0, 32'h100, "R10");
        // R12: read and write in the same cycle returns the old value
        hold = m_reg[5][4];
        op(1, 1, adr(5, 4), 32'h0BAD_F00D, '0, '0, "R12");
        check("R12", bus_rdata, hold, "read before write");
        @(negedge clk);
        check("R12", bus_rdata, hold, "rdata held");

        // Random mix on a few channels
        for (int n = 0; n < 4000; n++) begin
            int ch = ($urandom % 8 == 0) ? 31 : int'($urandom % 4);
            int pick = int'($urandom % 10);
            int ri;
            logic [31:0] d = $urandom;
            logic [NCH-1:0] k = '0, s = '0;
            case (pick)
                0, 1, 2, 3: ri = 0;
                4: ri = 3;
                5: ri = 1;
                6: ri = 4 + int'($urandom % 3);
                7: ri = 10 + int'($urandom % 6);
                default: ri = int'($urandom % 32);
            endcase
            if (ri == 0) begin
                d[31:16] = d[31:16] | (($urandom % 2) ? 16'h5000 : 16'h8000);
            end
            if ($urandom % 8 == 0) k[$urandom % 4] = 1;
            if ($urandom % 8 == 0) s[$urandom % 4] = 1;
            op($urandom % 4 != 0, $urandom % 2 == 0, adr(ch, ri), d, k, s, "R3");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule